// File: doc/BRIEF.md
# Symbol-Correcting Memory Word Protector

This block guards the words of a 512-entry, 72-bit-wide block RAM against clustered upsets. It uses a short Reed-Solomon code with eight 9-bit symbols per word over GF(2^9): four symbols carry 36 data bits and four symbols carry check information. Encoding and syndrome computation are fixed binary matrix products. Both the generator and the check matrix are worked out from the field arithmetic when the design is elaborated, so the hardware holds only XOR trees. There is no polynomial divider and no key-equation solver.

The write side is purely combinational. Data goes in and the 72-bit codeword comes out, ready to be written to the RAM. The read side takes the 72-bit word that the RAM returns through a valid/ready handshake. It computes the syndrome and tests the syndrome against every single-symbol error site in parallel. It registers the corrected data and two flags once.

Back-pressure rules: a word is accepted on a rising edge where `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output data and flags hold still and no new word is accepted. With `out_ready` held high, the block accepts one word on every clock cycle.

Top module: `rs_mem_ecc`

## Requirements
- R1: `wr_code[71:36]` equals `wr_data`, and `wr_code` is a codeword. Symbol i is bits [9i+8:9i] and is the coefficient of x^i. The field is built on x^9+x^4+1 with alpha = 9'h002. The codeword polynomial evaluates to zero at alpha^0, alpha^1, alpha^2 and alpha^3.
- R2: A read word that is a valid codeword yields `out_data` = bits [71:36], with `out_corrected` = 0 and `out_uncorrectable` = 0.
- R3: Any nonzero error value confined to any one of the eight symbols is removed. `out_data` equals the original data and `out_corrected` = 1.
- R4: Any error touching exactly two symbols sets `out_uncorrectable` = 1 and `out_corrected` = 0. In that case `out_data` equals bits [71:36] of the received word, unmodified.
- R5: With `out_ready` high, the result for a word accepted on clock edge k is presented with `out_valid` = 1 after edge k+1 is not needed: it appears right after edge k.
- R6: While `out_valid` = 1 and `out_ready` = 0, `rd_ready` is 0, and `out_data`, `out_corrected` and `out_uncorrectable` hold their values.
- R7: While `rst_n` is low, `out_valid` is 0. After reset is released, `rd_ready` is 1.
- R8: Every burst of 1 to 8 adjacent flipped bits that lies inside one symbol is corrected as in R3. An 8-bit burst that straddles a symbol boundary is reported as in R4.
- R9: `out_corrected` and `out_uncorrectable` are never both 1 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 36 | Data to be protected |
| wr_code | output | 72 | Codeword for the RAM (combinational) |
| rd_valid | input | 1 | Read word present |
| rd_ready | output | 1 | Block can take a read word |
| rd_code | input | 72 | Word returned by the RAM |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 36 | Corrected (or raw) data |
| out_corrected | output | 1 | A single-symbol error was removed |
| out_uncorrectable | output | 1 | Nonzero syndrome with no single-symbol match |

## Verification
The bench sweeps every one of the 511 nonzero error values at each of the eight symbol sites. A locator that compared the wrong power of alpha, or that omitted a syndrome equation, would leave some of these values uncorrected or flip the wrong symbol. Random two-symbol errors and 8-bit bursts across symbol boundaries must be flagged and passed through raw; a locator that accepted a partial syndrome match would miscorrect them instead. A stall with a second word waiting checks that the output register neither changes nor drops or duplicates a word, and the scoreboard's ordering exposes any lost or reordered result.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;
  localparam int SYM_W  = 9;
  localparam int N_SYM  = 8;
  localparam int K_SYM  = 4;
  localparam int R_SYM  = N_SYM - K_SYM;
  localparam int DATA_W = K_SYM * SYM_W;
  localparam int CODE_W = N_SYM * SYM_W;
  localparam int CHK_W  = R_SYM * SYM_W;
  localparam logic [SYM_W:0] FIELD_POLY = 10'h211;

  typedef logic [SYM_W-1:0] sym_t;

  // Product of two field elements, shift-and-add with modular reduction.
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      if (x[SYM_W-1]) x = (x << 1) ^ FIELD_POLY[SYM_W-1:0];
      else            x = x << 1;
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction

  // Generator polynomial: product of (x + alpha^j) for j < R_SYM, monic.
  function automatic logic [(R_SYM+1)*SYM_W-1:0] gen_poly();
    sym_t g [R_SYM+1];
    sym_t nxt [R_SYM+1];
    logic [(R_SYM+1)*SYM_W-1:0] flat;
    for (int k = 0; k <= R_SYM; k++) g[k] = '0;
    g[0] = sym_t'(1);
    for (int j = 0; j < R_SYM; j++) begin
      for (int k = 0; k <= R_SYM; k++) begin
        nxt[k] = gf_mul(g[k], gf_alpha_pow(j));
        if (k > 0) nxt[k] = nxt[k] ^ g[k-1];
      end
      for (int k = 0; k <= R_SYM; k++) g[k] = nxt[k];
    end
    for (int k = 0; k <= R_SYM; k++) flat[k*SYM_W +: SYM_W] = g[k];
    return flat;
  endfunction

  // Column b holds the check symbols produced by data bit b alone.
  function automatic logic [DATA_W*CHK_W-1:0] build_chk_matrix();
    logic [(R_SYM+1)*SYM_W-1:0] gp;
    logic [DATA_W*CHK_W-1:0] m;
    sym_t c [N_SYM];
    sym_t q;
    gp = gen_poly();
    m  = '0;
    for (int b = 0; b < DATA_W; b++) begin
      for (int i = 0; i < N_SYM; i++) c[i] = '0;
      c[R_SYM + b / SYM_W] = sym_t'(1) << (b % SYM_W);
      for (int d = N_SYM - 1; d >= R_SYM; d--) begin
        q = c[d];
        for (int k = 0; k <= R_SYM; k++)
          c[d - R_SYM + k] = c[d - R_SYM + k] ^ gf_mul(q, gp[k*SYM_W +: SYM_W]);
      end
      for (int j = 0; j < R_SYM; j++) m[b*CHK_W + j*SYM_W +: SYM_W] = c[j];
    end
    return m;
  endfunction

  // Column q holds the syndrome contribution of received bit q.
  function automatic logic [CODE_W*CHK_W-1:0] build_syn_matrix();
    logic [CODE_W*CHK_W-1:0] m;
    for (int q = 0; q < CODE_W; q++)
      for (int j = 0; j < R_SYM; j++)
        m[q*CHK_W + j*SYM_W +: SYM_W] =
          gf_mul(sym_t'(1) << (q % SYM_W), gf_alpha_pow((q / SYM_W) * j));
    return m;
  endfunction
endpackage

// File: rtl/rs_encoder.sv
module rs_encoder
  import rs_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [DATA_W*CHK_W-1:0] GMAT = build_chk_matrix();

  logic [CHK_W-1:0] chk;

  always_comb begin
    chk = '0;
    for (int b = 0; b < DATA_W; b++)
      chk = chk ^ (GMAT[b*CHK_W +: CHK_W] & {CHK_W{data_i[b]}});
  end

  assign code_o = {data_i, chk};
endmodule

// File: rtl/rs_syndrome.sv
module rs_syndrome
  import rs_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CHK_W-1:0]  syn_o
);
  localparam logic [CODE_W*CHK_W-1:0] HMAT = build_syn_matrix();

  for (genvar j = 0; j < R_SYM; j++) begin : g_eq
    sym_t acc;
    always_comb begin
      acc = '0;
      for (int q = 0; q < CODE_W; q++)
        acc = acc ^ (HMAT[q*CHK_W + j*SYM_W +: SYM_W] & {SYM_W{code_i[q]}});
    end
    assign syn_o[j*SYM_W +: SYM_W] = acc;
  end
endmodule

// File: rtl/rs_locator.sv
module rs_locator
  import rs_ecc_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  output logic [CODE_W-1:0] flip_o,
  output logic              fixable_o,
  output logic              fatal_o
);
  sym_t s0;
  logic [N_SYM-1:0] site;

  assign s0 = syn_i[SYM_W-1:0];

  // A single error e at symbol p gives S_j = e * alpha^(p*j); S_0 is e itself.
  always_comb begin
    for (int p = 0; p < N_SYM; p++) begin
      site[p] = (s0 != '0);
      for (int j = 1; j < R_SYM; j++)
        if (syn_i[j*SYM_W +: SYM_W] != gf_mul(s0, gf_alpha_pow(p * j)))
          site[p] = 1'b0;
      flip_o[p*SYM_W +: SYM_W] = site[p] ? s0 : '0;
    end
  end

  assign fixable_o = |site;
  assign fatal_o   = (syn_i != '0) && !fixable_o;

  // R3: distance five leaves at most one matching site for any syndrome
  always_comb begin
    a_r3_one_site: assert ($onehot0(site));
  end
endmodule

// File: rtl/rs_mem_ecc.sv
module rs_mem_ecc
  import rs_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [CODE_W-1:0] rd_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_corrected,
  output logic              out_uncorrectable
);
  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] fixed;
  logic              hit;
  logic              miss;
  logic              take;

  rs_encoder u_enc (.data_i(wr_data), .code_o(wr_code));
  rs_syndrome u_syn (.code_i(rd_code), .syn_o(syn));
  rs_locator u_loc (.syn_i(syn), .flip_o(flip), .fixable_o(hit), .fatal_o(miss));

  assign fixed    = rd_code ^ flip;
  assign rd_ready = !out_valid || out_ready;
  assign take     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_data          <= '0;
      out_corrected     <= 1'b0;
      out_uncorrectable <= 1'b0;
    end else if (take) begin
      out_valid         <= 1'b1;
      out_data          <= fixed[CODE_W-1 -: DATA_W];
      out_corrected     <= hit;
      out_uncorrectable <= miss;
    end else if (out_ready) begin
      out_valid         <= 1'b0;
    end
  end

  a_r5_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_corrected) && $stable(out_uncorrectable)));

  a_r2_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (take && syn == '0) |=> (!out_corrected && !out_uncorrectable &&
      out_data == $past(rd_code[CODE_W-1 -: DATA_W])));

  a_r4_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && miss) |=> (out_uncorrectable &&
      out_data == $past(rd_code[CODE_W-1 -: DATA_W])));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_corrected && out_uncorrectable));
endmodule

// File: tb/sim_rs_mem_ecc.sv
module sim_rs_mem_ecc;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 9;
  localparam int NS = 8;
  localparam int DW = 36;
  localparam int CW = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_code;
  logic rd_valid, rd_ready, out_valid, out_ready;
  logic [CW-1:0] rd_code;
  logic [DW-1:0] out_data;
  logic out_corrected, out_uncorrectable;

  rs_mem_ecc u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_code(rd_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DW-1:0] data;
    logic corr;
    logic unc;
    string req;
    int acc;
    bit lat;
  } exp_t;
  exp_t sbq[$];

  function automatic logic [SW-1:0] m_mul(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] r = '0;
    logic [SW-1:0] x = a;
    for (int i = 0; i < SW; i++) begin
      if (b[i]) r = r ^ x;
      x = x[SW-1] ? ((x << 1) ^ 9'h011) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] m_apow(int e);
    logic [SW-1:0] r = 9'd1;
    for (int i = 0; i < e; i++) r = m_mul(r, 9'd2);
    return r;
  endfunction

  function automatic bit m_is_code(logic [CW-1:0] w);
    logic [SW-1:0] s;
    for (int j = 0; j < 4; j++) begin
      s = '0;
      for (int i = 0; i < NS; i++) s = s ^ m_mul(w[i*SW +: SW], m_apow(i * j));
      if (s != '0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [CW-1:0] act, logic [CW-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic encode(input logic [DW-1:0] d, output logic [CW-1:0] cw);
    wr_data = d;
    #1;
    cw = wr_code;
  endtask

  task automatic send(input logic [CW-1:0] w, input logic [DW-1:0] ed, input bit ec,
                      input bit eu, input string req, input bit lat);
    exp_t it;
    rd_code  = w;
    rd_valid = 1'b1;
    forever begin
      if (rd_ready) begin
        it.data = ed; it.corr = ec; it.unc = eu; it.req = req;
        it.acc = cyc; it.lat = lat;
        sbq.push_back(it);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    rd_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever a result is taken.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "unexpected result", CW'(out_data), '0);
        end else begin
          e = sbq.pop_front();
          check(out_data == e.data && out_corrected == e.corr &&
                out_uncorrectable == e.unc && (!e.lat || (cyc - e.acc) == 1),
                e.req, "data/corr/unc/latency",
                {out_data, out_corrected, out_uncorrectable, 34'(cyc - e.acc)},
                {e.data, e.corr, e.unc, 34'(1)});
        end
      end
    end
  end

  initial begin
    logic [CW-1:0] cw;
    logic [CW-1:0] bad;
    logic [DW-1:0] d;
    logic [DW-1:0] held;
    rd_valid = 0; out_ready = 1; wr_data = '0; rd_code = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", CW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_ready == 1'b1 && out_valid == 1'b0, "R7", "ready after reset",
          CW'({rd_ready, out_valid}), CW'(2'b10));

    // R1: systematic layout and codeword property
    for (int k = 0; k < 24; k++) begin
      if (k == 0) d = '0;
      else if (k == 1) d = '1;
      else if (k < 12) d = DW'(1) << (k * 3);
      else d = DW'({$urandom(), $urandom()});
      encode(d, cw);
      check(cw[CW-1:DW] == d && m_is_code(cw), "R1", "encoder", cw, {d, 36'h0});
    end

    // R2 and R5: clean words, back to back, one cycle to output
    for (int k = 0; k < 16; k++) begin
      d = DW'({$urandom(), $urandom()});
      encode(d, cw);
      send(cw, d, 1'b0, 1'b0, "R2 R5", 1'b1);
    end

    // R3: every nonzero value at every symbol
    for (int p = 0; p < NS; p++) begin
      d = DW'({$urandom(), $urandom()});
      encode(d, cw);
      for (int v = 1; v < 512; v++) begin
        bad = cw ^ (CW'(v) << (SW * p));
        send(bad, d, 1'b1, 1'b0, "R3", 1'b1);
      end
    end

    // R8: bursts inside a symbol, then bursts across a boundary
    for (int p = 0; p < NS; p++) begin
      d = DW'({$urandom(), $urandom()});
      encode(d, cw);
      for (int len = 1; len <= 8; len++)
        for (int o = 0; o + len <= SW; o++) begin
          bad = cw ^ (((CW'(1) << len) - CW'(1)) << (SW * p + o));
          send(bad, d, 1'b1, 1'b0, "R8", 1'b1);
        end
    end
    for (int b = 1; b < NS; b++)
      for (int o = 1; o < 8; o++) begin
        d = DW'({$urandom(), $urandom()});
        encode(d, cw);
        bad = cw ^ (CW'(8'hFF) << (SW * b - o));
        send(bad, bad[CW-1:DW], 1'b0, 1'b1, "R8", 1'b1);
      end

    // R4 and R9: random two-symbol errors
    for (int k = 0; k < 400; k++) begin
      int p1, p2;
      p1 = $urandom_range(0, NS - 1);
      p2 = (p1 + $urandom_range(1, NS - 1)) % NS;
      d = DW'({$urandom(), $urandom()});
      encode(d, cw);
      bad = cw ^ (CW'($urandom_range(1, 511)) << (SW * p1))
               ^ (CW'($urandom_range(1, 511)) << (SW * p2));
      send(bad, bad[CW-1:DW], 1'b0, 1'b1, "R4 R9", 1'b1);
    end

    // R6: stall with a second word waiting
    while (sbq.size() != 0) @(negedge clk);
    out_ready = 1'b0;
    d = 36'h123456789;
    encode(d, cw);
    send(cw ^ (CW'(9'h1A5) << (SW * 6)), d, 1'b1, 1'b0, "R6", 1'b0);
    held = out_data;
    encode(36'hABCDEF012, cw);
    rd_code = cw; rd_valid = 1'b1;
    check(rd_ready == 1'b0 && out_valid == 1'b1, "R6", "ready low while stalled",
          CW'({rd_ready, out_valid}), CW'(2'b01));
    repeat (3) @(negedge clk);
    check(out_valid && out_data == held && out_corrected && !rd_ready, "R6",
          "output held", CW'(out_data), CW'(held));
    begin
      exp_t it;
      it.data = 36'hABCDEF012; it.corr = 0; it.unc = 0; it.req = "R6";
      it.acc = 0; it.lat = 0;
      sbq.push_back(it);
    end
    out_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;

    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule